// File: doc/BRIEF.md
# Timer-Synchronized Serial Transmitter

This block sends bytes on an asynchronous serial line as 10-bit frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Bit timing does not come from a private baud generator. An external timer delivers a one-cycle overflow strobe. That strobe is passed through as is, or every second strobe is kept, depending on a rate select input. The resulting ticks advance a free-running 16-state slice counter, and every wrap of that counter marks a bit boundary.

A byte write arms the transmitter. The write does not restart the slice counter. The start bit therefore appears at the next wrap of the free-running counter, so the first bit's delay from the write varies between writes, while every bit after it lasts exactly 16 ticks. After the stop bit is placed on the line, a sticky done flag rises and stays high until it is cleared. A new byte may be written from the cycle after the stop bit is driven. Its start bit waits for the next wrap, which gives the stop bit its full length.

Top module: `uart_tick_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `txd` is 1 and `tx_done` is 0. The slice counter and the rate-divider phase restart from zero.
- R2: With `rate_half` = 0, every cycle with `ovf_pulse` high is one tick. With `rate_half` = 1, only every second `ovf_pulse` counts as a tick. The divider phase advances only on strobes seen while `rate_half` = 1, and the first such strobe after reset is the one skipped.
- R3: The slice counter counts ticks modulo 16 and is never restarted by a write. A rollover is a tick that arrives while the counter holds 15.
- R4: A write (`wr_en` high) made while idle captures `wr_byte`. The start bit is driven at the first rollover in a cycle strictly after the write cycle.
- R5: Each rollover puts the next frame bit on `txd`, in the order 0, `wr_byte[0]` … `wr_byte[7]`, 1. `txd` is registered and shows the new bit in the cycle after the rollover cycle.
- R6: `txd` changes only in the cycle after a rollover, and it stays 1 whenever no frame is being sent.
- R7: `tx_done` rises one cycle after `txd` takes the stop bit, which is the 10th rollover after the write. A write is accepted again from the cycle after that 10th rollover.
- R8: A write made while a byte is waiting for its start rollover, or while a frame is being sent, is ignored. The frame in progress keeps its original data.
- R9: `tx_done` stays 1 until a cycle with `done_clr` high, and it reads 0 in the following cycle. If the flag is being set in the same cycle as a clear, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_pulse | input | 1 | One-cycle strobe from the external timer overflow |
| rate_half | input | 1 | 0: bit rate is strobe rate / 16; 1: strobe rate / 32 |
| wr_en | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output line, idles high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
The assertions assume that every input is a known value after reset and changes only synchronously to `clk`. They also assume that `ovf_pulse` and `rate_half` are sampled together, so the divider's alternation is judged only over strobes seen while half rate is selected. The bench drives all inputs at the falling edge. It produces the strobe from a gap counter, changes the rate select only between frames, and times writes from a pseudo-random sequence, so that writes land on rollover cycles, inside armed and sending windows, and right after completion. A behavioural model built from a bit queue predicts `txd` and `tx_done` for every cycle.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;

    localparam int unsigned DEF_SLICES = 16;
    localparam int unsigned DEF_DATA_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND  = 2'd2
    } tx_state_e;

    function automatic int unsigned frame_len(input int unsigned data_w);
        return data_w + 2;
    endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale (
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic half,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)              phase_q <= 1'b0;
        else if (ovf && half) phase_q <= ~phase_q;
    end

    assign tick = ovf && (!half || phase_q);

    // Independent tracker: remembers whether the last half-rate strobe was skipped.
    logic skipped_q;
    always_ff @(posedge clk) begin
        if (rst)              skipped_q <= 1'b0;
        else if (ovf && half) skipped_q <= !tick;
    end

    p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
        (ovf && half) |-> (tick == skipped_q));
    p_full_rate_r2: assert property (@(posedge clk) disable iff (rst)
        (ovf && !half) |-> tick);
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !ovf |-> !tick);

endmodule

// File: rtl/slice_counter.sv
module slice_counter #(
    parameter int unsigned SLICES = uart_tick_pkg::DEF_SLICES
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic roll
);
    localparam int unsigned SLICE_W = $clog2(SLICES);
    localparam logic [SLICE_W-1:0] LAST = SLICE_W'(SLICES - 1);

    logic [SLICE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign roll = tick && (cnt_q == LAST);

    p_free_run_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == SLICE_W'(($past(cnt_q) + 1) % SLICES)));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tick_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              roll,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    output logic              txd,
    output logic              done
);
    localparam int unsigned FRAME_W = frame_len(DATA_W);
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    tx_state_e          state_q;
    logic [DATA_W-1:0]  hold_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   nbits_q;
    logic               txd_q;
    logic               last_q;
    logic               done_q;
    logic [FRAME_W-1:0] frame;

    assign frame = {1'b1, hold_q, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            hold_q  <= '0;
            shreg_q <= '1;
            nbits_q <= '0;
            txd_q   <= 1'b1;
            last_q  <= 1'b0;
        end else begin
            last_q <= 1'b0;
            case (state_q)
                TX_IDLE: begin
                    if (wr) begin
                        hold_q  <= wr_data;
                        state_q <= TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (roll) begin
                        txd_q   <= frame[0];
                        shreg_q <= {1'b1, frame[FRAME_W-1:1]};
                        nbits_q <= CNT_W'(1);
                        state_q <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (roll) begin
                        txd_q   <= shreg_q[0];
                        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                        nbits_q <= nbits_q + 1'b1;
                        if (nbits_q == LAST_BIT) begin
                            state_q <= TX_IDLE;
                            last_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         done_q <= 1'b0;
        else if (last_q) done_q <= 1'b1;
        else if (clr)    done_q <= 1'b0;
    end

    assign txd  = txd_q;
    assign done = done_q;

    p_line_on_roll_r6: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(txd_q));
    p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_IDLE) |-> txd_q);
    p_done_after_stop_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (txd_q && state_q != TX_SEND));
    p_busy_keeps_data_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != TX_IDLE) |=> $stable(hold_q));
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done_q && !clr) |=> done_q);

endmodule

// File: rtl/uart_tick_tx.sv
module uart_tick_tx
    import uart_tick_pkg::*;
#(
    parameter int unsigned SLICES = DEF_SLICES,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ovf_pulse,
    input  logic              rate_half,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              done_clr,
    output logic              txd,
    output logic              tx_done
);
    logic tick;
    logic roll;

    baud_prescale u_prescale (
        .clk  (clk),
        .rst  (rst),
        .ovf  (ovf_pulse),
        .half (rate_half),
        .tick (tick)
    );

    slice_counter #(.SLICES(SLICES)) u_slices (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .roll (roll)
    );

    tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .roll    (roll),
        .wr      (wr_en),
        .wr_data (wr_byte),
        .clr     (done_clr),
        .txd     (txd),
        .done    (tx_done)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (txd && !tx_done));

endmodule

// File: tb/uart_tick_tx_test.sv
module uart_tick_tx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf = 1'b0;
    logic       half = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wbyte = 8'h00;
    logic       clr = 1'b0;
    logic       txd;
    logic       done;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    int gap = 2;
    int gap_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_tick_tx uut (
        .clk(clk), .rst(rst), .ovf_pulse(ovf), .rate_half(half),
        .wr_en(wr), .wr_byte(wbyte), .done_clr(clr),
        .txd(txd), .tx_done(done)
    );

    // Behavioural reference model
    bit   m_phase;
    int   m_slice;
    bit   m_q[$];
    bit   m_pending;
    logic [7:0] m_byte;
    bit   m_txd;
    bit   m_done;
    bit   m_pulse;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_slice = 0; m_q.delete(); m_pending = 0;
            m_byte = 0; m_txd = 1; m_done = 0; m_pulse = 0;
        end else begin
            bit tk, rl, idle_pre, new_pulse;
            idle_pre = !m_pending && (m_q.size() == 0);
            tk = 0;
            if (ovf) begin
                if (!half) tk = 1;
                else begin
                    tk = m_phase;
                    m_phase = !m_phase;
                end
            end
            rl = tk && (m_slice == 15);
            if (tk) m_slice = (m_slice + 1) % 16;
            new_pulse = 0;
            if (rl) begin
                if (m_pending) begin
                    m_q.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_q.push_back(m_byte[i]);
                    m_q.push_back(1'b1);
                    m_pending = 0;
                end
                if (m_q.size() > 0) begin
                    m_txd = m_q.pop_front();
                    if (m_q.size() == 0) new_pulse = 1;
                end
            end
            if (wr && idle_pre) begin
                m_pending = 1;
                m_byte = wbyte;
            end
            if (m_pulse) m_done = 1;
            else if (clr) m_done = 0;
            m_pulse = new_pulse;
        end
    end

    // Strobe generator
    always @(negedge clk) begin
        if (gap_cnt >= gap - 1) begin
            gap_cnt <= 0;
            ovf <= 1'b1;
        end else begin
            gap_cnt <= gap_cnt + 1;
            ovf <= 1'b0;
        end
    end

    // Lock-step comparison every cycle, before new inputs are applied
    always @(negedge clk) begin
        if (!rst && !finished) begin
            compared++;
            if (txd !== m_txd) begin
                mismatched++;
                $display("FAIL %s txd: actual=%b expected=%b at %0t", cur_req, txd, m_txd, $time);
            end
            compared++;
            if (done !== m_done) begin
                mismatched++;
                $display("FAIL %s tx_done: actual=%b expected=%b at %0t", cur_req, done, m_done, $time);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr = 1'b1; wbyte = b;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (m_done) break;
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cycles(3);
        check("R1 txd in reset", txd, 1'b1);
        check("R1 done in reset", done, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd after reset", txd, 1'b1);
        check("R1 done after reset", done, 1'b0);

        // R4 / R5: one frame at full rate
        cur_req = "R5";
        gap = 2; half = 1'b0;
        write_byte(8'hA5);
        wait_done(600);
        cur_req = "R7";
        check("R7 done raised after frame", done, 1'b1);
        check("R6 line idle high after frame", txd, 1'b1);
        cycles(100);
        cur_req = "R9";
        check("R9 done held without clear", done, 1'b1);
        pulse_clear();
        check("R9 done cleared", done, 1'b0);

        // R8: writes while armed or sending are ignored
        cur_req = "R8";
        write_byte(8'h3C);
        cycles(5);
        write_byte(8'hFF);
        cycles(150);
        write_byte(8'h00);
        wait_done(600);
        check("R8 only first byte completed", done, 1'b1);
        pulse_clear();

        // R2: half rate with a strobe every cycle, then every third cycle
        cur_req = "R2";
        half = 1'b1; gap = 1;
        cycles(4);
        write_byte(8'h96);
        wait_done(800);
        check("R2 half-rate frame completed", done, 1'b1);
        pulse_clear();
        gap = 3;
        cycles(7);
        write_byte(8'h01);
        wait_done(2200);
        check("R2 slow half-rate frame completed", done, 1'b1);

        // R9: clear held high across completion, set wins in its cycle
        cur_req = "R9";
        half = 1'b0; gap = 1;
        clr = 1'b1;
        cycles(3);
        write_byte(8'h5A);
        wait_done(400);
        cycles(2);
        clr = 1'b0;
        check("R9 clear held drops flag", done, 1'b0);

        // R7: back-to-back write right after completion
        cur_req = "R7";
        write_byte(8'hC3);
        wait_done(400);
        wr = 1'b1; wbyte = 8'h81;
        @(negedge clk);
        wr = 1'b0;
        pulse_clear();
        wait_done(400);
        check("R7 back-to-back frame completed", done, 1'b1);
        pulse_clear();

        // R3 / R4 / R6: writes at pseudo-random offsets from rollovers
        cur_req = "R3";
        gap = 1; half = 1'b0;
        for (int k = 0; k < 16; k++) begin
            lfsr = step(lfsr);
            cycles(int'(lfsr[4:0]) + 1);
            if (k[0]) cur_req = "R4"; else cur_req = "R6";
            write_byte(lfsr[15:8]);
            lfsr = step(lfsr);
            if (lfsr[0]) begin
                cycles(int'(lfsr[6:1]));
                write_byte(~lfsr[15:8]);
            end
            wait_done(400);
            if (lfsr[1]) pulse_clear();
        end
        cycles(20);
        check("R6 idle line high at end", txd, 1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule